// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits behind the bus-strobe qualifier of a byte-wide flash device. It turns a stream of qualified write cycles into start requests for the array engine. Each write cycle is one address and one data byte. Every command opens with two unlock writes: AAh at 555h, then 55h at 2AAh. A program command then takes a fourth write and issues a program request with that write's address and data. The erase and lockout commands add a second unlock pair and take six writes in all. The last write picks one of three actions:

- erase the whole array,
- erase one block,
- set the permanent boot-block lock.

The block also runs an identification mode. In that mode a separate read address returns the manufacturer byte, the device byte or the lock status. It maps any address onto one of five blocks; the parameter `TOP_BOOT` places the boot block at the top or the bottom of the array. When the lock is set, the boot block is shielded from both kinds of erase.

The state machine has these states:

- IDLE: read mode.
- UNL1 and UNL2: after the first and second unlock write.
- PROG: waiting for the program data write.
- ER1, ER2 and ER3: the second unlock pair and then the final erase or lock write.
- CHIP: a whole-array erase is running.

Its transitions are:

- IDLE→UNL1 on AA@555.
- UNL1→UNL2 on 55@2AA.
- UNL2→PROG on A0@555.
- UNL2→ER1 on 80@555.
- UNL2→IDLE on 90@555, which enters identification mode, or on F0@555, which leaves it.
- PROG→IDLE on any write, which issues the program request.
- ER1→ER2 on AA@555.
- ER2→ER3 on 55@2AA.
- ER3→CHIP on 10@555.
- ER3→IDLE on 30 at any address (block erase) or on 40@555 (lock).
- CHIP→IDLE when `op_done` is seen.
- Any write that does not fit the sequence sends the machine back to IDLE.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the sequencer is in read mode: `id_mode`=0, `boot_locked`=0, `chip_busy`=0, `prog_req`=0, `erase_req`=0, `id_rdata`=00h.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h and then D@A give `prog_req`=1 for exactly one cycle, starting the cycle after the fourth write, with `prog_addr`=A and `prog_data`=D.
- R3: The writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 give a one-cycle `erase_req` with `erase_all`=1 and `erase_keep_boot` equal to `boot_locked`. `chip_busy` rises in the same cycle.
- R4: The same prefix, ending instead with 30h at address A, gives a one-cycle `erase_req` with `erase_all`=0 and `erase_blk` set to the block code of A.
- R5: Block codes are 0 = boot (16K), 1 = lower-addressed 8K parameter block, 2 = higher 8K parameter block, 3 = 96K main, 4 = 128K main. With `TOP_BOOT`=1 the ranges are 00000–1FFFF→4, 20000–37FFF→3, 38000–39FFF→1, 3A000–3BFFF→2 and 3C000–3FFFF→0. With `TOP_BOOT`=0 they are 00000–03FFF→0, 04000–05FFF→1, 06000–07FFF→2, 08000–1FFFF→3 and 20000–3FFFF→4.
- R6: The erase prefix ending in 40h@555h sets `boot_locked`=1 and `id_mode`=1. The lock stays set until reset.
- R7: While locked, a block erase whose address maps to code 0 produces no `erase_req`. A chip erase still proceeds, with `erase_keep_boot`=1.
- R8: The unlock pair followed by 90h@555h sets `id_mode`. In identification mode, `id_rdata` is 9Dh when `rd_addr[1:0]`=00. It is 1Dh (top boot) or 2Dh (bottom boot) when `rd_addr[1:0]`=01. Outside identification mode `id_rdata` is 00h.
- R9: In identification mode, when `rd_addr` lies in the boot block and `rd_addr[1:0]`=10, `id_rdata` is {7'b0, `boot_locked`}. Offset 10 outside the boot block reads 00h.
- R10: Identification mode is left either by one F0h write at any address while idle, or by the unlock pair followed by F0h@555h.
- R11: While `chip_busy`=1 every write is ignored. `chip_busy` clears the cycle after `op_done`=1, and the sequencer is then back in read mode.
- R12: A write that breaks a sequence returns the machine to IDLE. Unlock and command addresses are matched on address bits [10:0] only.
- R13: In identification mode, the program, erase and lock command bytes after the unlock pair are refused. `id_mode` stays 1 and no request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle qualified write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| op_done | input | 1 | Array engine finished the running chip erase |
| rd_addr | input | ADDR_W | Read address for identification data |
| prog_req | output | 1 | Program start pulse |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | 8 | Program data byte |
| erase_req | output | 1 | Erase start pulse |
| erase_all | output | 1 | 1 = chip erase, 0 = block erase |
| erase_blk | output | 3 | Block code for block erase |
| erase_keep_boot | output | 1 | Chip erase must spare the boot block |
| id_mode | output | 1 | Identification mode active |
| boot_locked | output | 1 | Boot-block lock flag |
| chip_busy | output | 1 | Chip erase in progress |
| id_rdata | output | 8 | Identification read data |

## Verification
A corrupted state usually goes unseen until a later write: a lost unlock state shows as a missing request pulse one cycle after the command's last write. A wrong block code appears on `erase_blk` in that same cycle. A lost lock or identification flag is visible at once through `id_rdata` with the lock-status read address, or through `id_mode`. A stuck CHIP state shows as `chip_busy` staying high after `op_done` and as later commands producing no pulse. Each scenario therefore samples one cycle after the final write and reads the identification data after each mode change.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
    localparam logic [10:0] UNL_A = 11'h555;
    localparam logic [10:0] UNL_B = 11'h2AA;

    localparam logic [7:0] CMD_KEY1  = 8'hAA;
    localparam logic [7:0] CMD_KEY2  = 8'h55;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_SETUP = 8'h80;
    localparam logic [7:0] CMD_IDENT = 8'h90;
    localparam logic [7:0] CMD_EXIT  = 8'hF0;
    localparam logic [7:0] CMD_CHIP  = 8'h10;
    localparam logic [7:0] CMD_BLK   = 8'h30;
    localparam logic [7:0] CMD_LOCK  = 8'h40;

    typedef enum logic [2:0] {
        BLK_BOOT   = 3'd0,
        BLK_PAR_LO = 3'd1,
        BLK_PAR_HI = 3'd2,
        BLK_MAIN_S = 3'd3,
        BLK_MAIN_L = 3'd4
    } blk_t;

    typedef enum logic [2:0] {
        S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ER1, S_ER2, S_ER3, S_CHIP
    } seq_state_t;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_PROG, ACT_CHIP, ACT_BLK, ACT_LOCK, ACT_ID_ON, ACT_ID_OFF
    } seq_act_t;

    // True when the low address bits and the data byte both match.
    function automatic logic hit(input logic [10:0] a, input logic [7:0] d,
                                 input logic [10:0] ea, input logic [7:0] ed);
        return (a == ea) && (d == ed);
    endfunction
endpackage

// File: rtl/flash_blk_map.sv
module flash_blk_map
    import flash_seq_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic [4:0] hi_bits,   // five most significant address bits
    output blk_t       blk
);
    generate
        if (TOP_BOOT) begin : g_top
            always_comb begin
                if (hi_bits[4:1] == 4'b1111)       blk = BLK_BOOT;
                else if (hi_bits == 5'b11100)      blk = BLK_PAR_LO;
                else if (hi_bits == 5'b11101)      blk = BLK_PAR_HI;
                else if (hi_bits[4])               blk = BLK_MAIN_S;
                else                               blk = BLK_MAIN_L;
            end
        end else begin : g_bot
            always_comb begin
                if (hi_bits[4:1] == 4'b0000)       blk = BLK_BOOT;
                else if (hi_bits == 5'b00010)      blk = BLK_PAR_LO;
                else if (hi_bits == 5'b00011)      blk = BLK_PAR_HI;
                else if (!hi_bits[4])              blk = BLK_MAIN_S;
                else                               blk = BLK_MAIN_L;
            end
        end
    endgenerate
endmodule

// File: rtl/flash_id_rd.sv
module flash_id_rd
    import flash_seq_pkg::*;
#(
    parameter logic [7:0] MFR_ID = 8'h9D,
    parameter logic [7:0] DEV_ID = 8'h1D
) (
    input  logic       id_on,
    input  logic       locked,
    input  logic [1:0] rd_off,
    input  blk_t       rd_blk,
    output logic [7:0] rdata
);
    always_comb begin
        rdata = 8'h00;
        if (id_on) begin
            unique case (rd_off)
                2'b00:   rdata = MFR_ID;
                2'b01:   rdata = DEV_ID;
                2'b10:   rdata = (rd_blk == BLK_BOOT) ? {7'b0, locked} : 8'h00;
                default: rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  blk_t              wr_blk,
    input  logic              op_done,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              erase_req,
    output logic              erase_all,
    output blk_t              erase_blk,
    output logic              erase_keep_boot,
    output logic              id_on,
    output logic              locked,
    output logic              chip_busy
);
    seq_state_t  state_q, nxt;
    seq_act_t    act;
    logic [10:0] lo;

    assign lo        = wr_addr[10:0];
    assign chip_busy = (state_q == S_CHIP);

    always_comb begin
        nxt = state_q;
        act = ACT_NONE;
        unique case (state_q)
            S_IDLE: if (wr_en) begin
                if (hit(lo, wr_data, UNL_A, CMD_KEY1))   nxt = S_UNL1;
                else if (id_on && wr_data == CMD_EXIT)  act = ACT_ID_OFF;
            end
            S_UNL1: if (wr_en) nxt = hit(lo, wr_data, UNL_B, CMD_KEY2) ? S_UNL2 : S_IDLE;
            S_UNL2: if (wr_en) begin
                nxt = S_IDLE;
                if (lo == UNL_A) begin
                    if (wr_data == CMD_EXIT) begin
                        if (id_on) act = ACT_ID_OFF;
                    end else if (!id_on) begin
                        if (wr_data == CMD_PROG)        nxt = S_PROG;
                        else if (wr_data == CMD_SETUP)  nxt = S_ER1;
                        else if (wr_data == CMD_IDENT)  act = ACT_ID_ON;
                    end
                end
            end
            S_PROG: if (wr_en) begin
                nxt = S_IDLE;
                act = ACT_PROG;
            end
            S_ER1: if (wr_en) nxt = hit(lo, wr_data, UNL_A, CMD_KEY1) ? S_ER2 : S_IDLE;
            S_ER2: if (wr_en) nxt = hit(lo, wr_data, UNL_B, CMD_KEY2) ? S_ER3 : S_IDLE;
            S_ER3: if (wr_en) begin
                nxt = S_IDLE;
                if (hit(lo, wr_data, UNL_A, CMD_CHIP)) begin
                    nxt = S_CHIP;
                    act = ACT_CHIP;
                end else if (wr_data == CMD_BLK) begin
                    if (!(wr_blk == BLK_BOOT && locked)) act = ACT_BLK;
                end else if (hit(lo, wr_data, UNL_A, CMD_LOCK)) begin
                    act = ACT_LOCK;
                end
            end
            S_CHIP: if (op_done) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_req        <= 1'b0;
            prog_addr       <= '0;
            prog_data       <= 8'h00;
            erase_req       <= 1'b0;
            erase_all       <= 1'b0;
            erase_blk       <= BLK_BOOT;
            erase_keep_boot <= 1'b0;
            id_on           <= 1'b0;
            locked          <= 1'b0;
        end else begin
            prog_req  <= (act == ACT_PROG);
            erase_req <= (act == ACT_CHIP) || (act == ACT_BLK);
            if (act == ACT_PROG) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (act == ACT_CHIP || act == ACT_BLK) begin
                erase_all       <= (act == ACT_CHIP);
                erase_blk       <= wr_blk;
                erase_keep_boot <= (act == ACT_CHIP) && locked;
            end
            if (act == ACT_LOCK) locked <= 1'b1;
            if (act == ACT_ID_ON || act == ACT_LOCK) id_on <= 1'b1;
            else if (act == ACT_ID_OFF)              id_on <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int         ADDR_W     = 18,
    parameter bit         TOP_BOOT   = 1'b1,
    parameter logic [7:0] MFR_ID     = 8'h9D,
    parameter logic [7:0] DEV_ID_TOP = 8'h1D,
    parameter logic [7:0] DEV_ID_BOT = 8'h2D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              op_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              erase_req,
    output logic              erase_all,
    output logic [2:0]        erase_blk,
    output logic              erase_keep_boot,
    output logic              id_mode,
    output logic              boot_locked,
    output logic              chip_busy,
    output logic [7:0]        id_rdata
);
    localparam int         HI     = ADDR_W - 1;
    localparam logic [7:0] DEV_ID = TOP_BOOT ? DEV_ID_TOP : DEV_ID_BOT;

    blk_t wr_blk, rd_blk, er_blk;

    flash_blk_map #(.TOP_BOOT(TOP_BOOT)) u_wr_map (
        .hi_bits (wr_addr[HI -: 5]),
        .blk     (wr_blk)
    );

    flash_blk_map #(.TOP_BOOT(TOP_BOOT)) u_rd_map (
        .hi_bits (rd_addr[HI -: 5]),
        .blk     (rd_blk)
    );

    flash_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .wr_addr         (wr_addr),
        .wr_data         (wr_data),
        .wr_blk          (wr_blk),
        .op_done         (op_done),
        .prog_req        (prog_req),
        .prog_addr       (prog_addr),
        .prog_data       (prog_data),
        .erase_req       (erase_req),
        .erase_all       (erase_all),
        .erase_blk       (er_blk),
        .erase_keep_boot (erase_keep_boot),
        .id_on           (id_mode),
        .locked          (boot_locked),
        .chip_busy       (chip_busy)
    );

    assign erase_blk = er_blk;

    flash_id_rd #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
        .id_on  (id_mode),
        .locked (boot_locked),
        .rd_off (rd_addr[1:0]),
        .rd_blk (rd_blk),
        .rdata  (id_rdata)
    );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prog_req,
    input logic       erase_req,
    input logic       erase_all,
    input logic [2:0] erase_blk,
    input logic       erase_keep_boot,
    input logic       id_mode,
    input logic       boot_locked,
    input logic       chip_busy
);
    // R2 / R3: one start request at a time
    assert_single_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_req && erase_req));

    // R3: chip erase start raises busy together with the erase pulse
    assert_chip_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_all) |-> chip_busy);

    // R3 / R7: sparing of the boot block follows the lock flag
    assert_keep_boot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_all) |-> (erase_keep_boot == boot_locked));

    // R7: a locked boot block is never targeted by a block erase
    assert_boot_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_all && boot_locked) |-> (erase_blk != 3'd0));

    // R6: the lock never clears without reset
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_locked |=> boot_locked);

    // R6: setting the lock also enters identification mode
    assert_lock_idmode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_locked) |-> id_mode);

    // R11: no request can start while a chip erase is running
    assert_busy_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        chip_busy |=> (!prog_req && !erase_req));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .prog_req        (prog_req),
    .erase_req       (erase_req),
    .erase_all       (erase_all),
    .erase_blk       (erase_blk),
    .erase_keep_boot (erase_keep_boot),
    .id_mode         (id_mode),
    .boot_locked     (boot_locked),
    .chip_busy       (chip_busy)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        op_done = 1'b0;
    logic [17:0] rd_addr = '0;

    logic        prog_req, erase_req, erase_all, erase_keep_boot, id_mode, boot_locked, chip_busy;
    logic [17:0] prog_addr;
    logic [7:0]  prog_data, id_rdata;
    logic [2:0]  erase_blk;

    logic        b_prog_req, b_erase_req, b_erase_all, b_keep, b_id_mode, b_locked, b_busy;
    logic [17:0] b_prog_addr;
    logic [7:0]  b_prog_data, b_id_rdata;
    logic [2:0]  b_erase_blk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_seq #(.TOP_BOOT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .op_done(op_done), .rd_addr(rd_addr), .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_req(erase_req), .erase_all(erase_all),
        .erase_blk(erase_blk), .erase_keep_boot(erase_keep_boot), .id_mode(id_mode),
        .boot_locked(boot_locked), .chip_busy(chip_busy), .id_rdata(id_rdata)
    );

    flash_cmd_seq #(.TOP_BOOT(1'b0)) dut_bot (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .op_done(op_done), .rd_addr(rd_addr), .prog_req(b_prog_req), .prog_addr(b_prog_addr),
        .prog_data(b_prog_data), .erase_req(b_erase_req), .erase_all(b_erase_all),
        .erase_blk(b_erase_blk), .erase_keep_boot(b_keep), .id_mode(b_id_mode),
        .boot_locked(b_locked), .chip_busy(b_busy), .id_rdata(b_id_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(18'h00555, 8'hAA);
        wr(18'h002AA, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(18'h00555, 8'h80);
        unlock();
    endtask

    task automatic pulse_done();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    task automatic t_reset();
        rd_addr = 18'h0; #1;
        chk("R1 id_mode", id_mode, 0);
        chk("R1 boot_locked", boot_locked, 0);
        chk("R1 chip_busy", chip_busy, 0);
        chk("R1 prog_req", prog_req, 0);
        chk("R1 erase_req", erase_req, 0);
        chk("R1 id_rdata", id_rdata, 8'h00);
    endtask

    task automatic t_program();
        unlock();
        wr(18'h00555, 8'hA0);
        chk("R2 no early prog_req", prog_req, 0);
        wr(18'h12345, 8'h5A);
        chk("R2 prog_req", prog_req, 1);
        chk("R2 prog_addr", prog_addr, 18'h12345);
        chk("R2 prog_data", prog_data, 8'h5A);
        @(negedge clk);
        chk("R2 single pulse", prog_req, 0);
        // R12: upper address bits do not matter for the unlock match
        wr(18'h3F555, 8'hAA);
        wr(18'h1D2AA, 8'h55);
        wr(18'h2A555, 8'hA0);
        wr(18'h0FFFF, 8'h00);
        chk("R12 aliased unlock prog_req", prog_req, 1);
        chk("R12 aliased prog_addr", prog_addr, 18'h0FFFF);
    endtask

    task automatic t_break();
        wr(18'h00555, 8'hAA);
        wr(18'h002AB, 8'h55);
        wr(18'h00555, 8'hA0);
        wr(18'h00100, 8'h77);
        chk("R12 broken sequence no prog", prog_req, 0);
        unlock();
        wr(18'h00555, 8'h80);
        wr(18'h00555, 8'hAA);
        wr(18'h002AA, 8'h54);
        wr(18'h00555, 8'h10);
        chk("R12 broken erase no req", erase_req, 0);
        chk("R12 broken erase not busy", chip_busy, 0);
    endtask

    task automatic t_blkmap();
        logic [17:0] ad [12] = '{18'h00000, 18'h1FFFF, 18'h20000, 18'h37FFF, 18'h38000, 18'h39FFF,
                                 18'h3A000, 18'h3BFFF, 18'h3C000, 18'h3FFFF, 18'h04000, 18'h06000};
        logic [2:0] et [12] = '{3'd4, 3'd4, 3'd3, 3'd3, 3'd1, 3'd1, 3'd2, 3'd2, 3'd0, 3'd0, 3'd4, 3'd4};
        logic [2:0] eb [12] = '{3'd0, 3'd3, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd1, 3'd2};
        for (int i = 0; i < 12; i++) begin
            erase_prefix();
            wr(ad[i], 8'h30);
            chk("R4 erase_req", erase_req, 1);
            chk("R4 erase_all", erase_all, 0);
            chk("R5 top block code", erase_blk, et[i]);
            chk("R5 bottom block code", b_erase_blk, eb[i]);
        end
    endtask

    task automatic t_chip();
        erase_prefix();
        wr(18'h00555, 8'h10);
        chk("R3 erase_req", erase_req, 1);
        chk("R3 erase_all", erase_all, 1);
        chk("R3 keep_boot", erase_keep_boot, 0);
        chk("R3 chip_busy", chip_busy, 1);
        unlock();
        wr(18'h00555, 8'hA0);
        wr(18'h00042, 8'h11);
        chk("R11 write ignored while busy", prog_req, 0);
        chk("R11 still busy", chip_busy, 1);
        pulse_done();
        chk("R11 busy cleared", chip_busy, 0);
        unlock();
        wr(18'h00555, 8'hA0);
        wr(18'h00043, 8'h22);
        chk("R11 read mode after done", prog_req, 1);
    endtask

    task automatic t_id();
        unlock();
        wr(18'h00555, 8'h90);
        chk("R8 id_mode", id_mode, 1);
        rd_addr = 18'h00000; #1;
        chk("R8 mfr", id_rdata, 8'h9D);
        rd_addr = 18'h00001; #1;
        chk("R8 dev top", id_rdata, 8'h1D);
        chk("R8 dev bottom", b_id_rdata, 8'h2D);
        rd_addr = 18'h3C002; #1;
        chk("R9 lock status unlocked", id_rdata, 8'h00);
        rd_addr = 18'h00002; #1;
        chk("R9 non-boot offset 2", id_rdata, 8'h00);
        unlock();
        wr(18'h00555, 8'hA0);
        wr(18'h00050, 8'h33);
        chk("R13 no program in id mode", prog_req, 0);
        chk("R13 id mode kept", id_mode, 1);
        wr(18'h00123, 8'hF0);
        chk("R10 short exit", id_mode, 0);
        rd_addr = 18'h00000; #1;
        chk("R8 read outside id mode", id_rdata, 8'h00);
        unlock();
        wr(18'h00555, 8'h90);
        chk("R8 re-enter", id_mode, 1);
        unlock();
        wr(18'h00555, 8'hF0);
        chk("R10 long exit", id_mode, 0);
    endtask

    task automatic t_lock();
        erase_prefix();
        wr(18'h00555, 8'h40);
        chk("R6 locked", boot_locked, 1);
        chk("R6 id_mode", id_mode, 1);
        rd_addr = 18'h3C002; #1;
        chk("R9 lock status top", id_rdata, 8'h01);
        rd_addr = 18'h00002; #1;
        chk("R9 lock status bottom", b_id_rdata, 8'h01);
        wr(18'h00000, 8'hF0);
        chk("R10 exit after lock", id_mode, 0);
        chk("R6 lock held", boot_locked, 1);
        erase_prefix();
        wr(18'h3C000, 8'h30);
        chk("R7 boot erase ignored", erase_req, 0);
        chk("R7 non-boot on bottom accepted", b_erase_req, 1);
        chk("R7 bottom block code", b_erase_blk, 3'd4);
        erase_prefix();
        wr(18'h20000, 8'h30);
        chk("R7 other block allowed", erase_req, 1);
        erase_prefix();
        wr(18'h00555, 8'h10);
        chk("R7 chip erase req", erase_req, 1);
        chk("R7 keep boot", erase_keep_boot, 1);
        pulse_done();
        chk("R11 done after locked chip erase", chip_busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_break();
        t_blkmap();
        t_chip();
        t_id();
        t_lock();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule